// File: doc/BRIEF.md
# Continuous Read Address Stepper

This block pulls a run of consecutive words out of an asynchronous SRAM without pulsing a read strobe per word. Once a burst is accepted it drops the memory's output enable, presents the start address, waits a programmable number of cycles for the memory's data lines to follow, and captures the word. It then steps the address by one and repeats. Output enable stays low for the whole burst, so successive words come only from address changes.

A burst request carries a start address, a word count and a settle time. Captured words leave through a valid/ready stream. A stalled consumer freezes the address until the pending word is taken. A request flagged as a write is refused with a one-cycle error pulse. A request with a count of zero is dropped without touching the bus.

Top module: `crs_stream_reader`

## Requirements
- R1: While reset is asserted, and after it is released, `mem_oe_n` is high, `out_valid`, `done` and `req_err` are low, and `req_ready` is high.
- R2: An accepted read request with a nonzero count drives `mem_oe_n` low at the accepting clock edge. It stays low without a break until the final word has been captured. Words are captured only inside an accepted burst.
- R3: For start address A, word k (counting from 0) is the data bus value sampled while `mem_addr` equals A+k modulo 2^AW. Address k+1 appears only after word k has been accepted downstream.
- R4: With settle value S taken from `settle_cfg` at acceptance (0 is treated as 1), each word is captured exactly S clock edges after its address was presented. `out_valid` rises at that edge.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `mem_addr` hold their values.
- R6: On the clock edge after the final capture, `mem_oe_n` returns high and `done` is high for exactly one cycle. `done` is low at all other times.
- R7: A request with `req_write` high is refused. `req_err` is high for one cycle after the accepting edge, and no bus activity follows.
- R8: A read request with a count of zero is ignored. `mem_oe_n` stays high, no word is produced, and the block remains ready.
- R9: `req_ready` is low from acceptance of a burst until its final word has been taken downstream. It is high only when no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Burst request present |
| req_write | input | 1 | Request asks for a write (refused) |
| req_addr | input | AW | First word address |
| req_count | input | CW | Number of words to read |
| settle_cfg | input | TW | Settle cycles after each address change (0 acts as 1) |
| req_ready | output | 1 | Block idle and able to take a request |
| req_err | output | 1 | One-cycle pulse when a write request is refused |
| mem_addr | output | AW | Memory address lines |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_data | input | DW | Memory data lines |
| out_valid | output | 1 | Captured word available |
| out_data | output | DW | Captured word |
| out_ready | input | 1 | Consumer takes the word |
| done | output | 1 | One-cycle pulse after the final capture |

## Verification
The bench's memory model returns garbage until the address has been stable for the settle time. A design that samples one cycle early therefore returns wrong data, and one that samples late misses the exact capture-cycle check. Settle values 0, 1 and 15 are exercised. A random consumer stall pattern is applied, and a design that steps the address or lets the word change under a stall is flagged. A burst that crosses the top of the address space catches a stepper that does not wrap. A single-word burst with the consumer held off checks that output enable and done follow the capture and not the handshake. Write and zero-count requests are issued between bursts, and the bench checks that the bus stays quiet, so a design that starts a cycle for them is caught.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_WAIT   = 3'd2,
    ST_CLOSE  = 3'd3,
    ST_DRAIN  = 3'd4
  } crs_state_e;
endpackage

// File: rtl/crs_rst_sync.sv
`timescale 1ns/1ps
module crs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/crs_settle_timer.sv
`timescale 1ns/1ps
module crs_settle_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (run && cnt_q != ONE) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == ONE);

  // R4: a running count never sits at zero, or the capture would never come
  p_cnt_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q != '0);
  // R4: exactly one capture per address presentation
  p_expire_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/crs_addr_step.sv
`timescale 1ns/1ps
module crs_addr_step #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_d  = addr_q;
    addr_en = load | inc;
    if (load)     addr_d = load_addr;
    else if (inc) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R3: a burst start and a step never coincide
  p_load_inc_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && inc));
endmodule

// File: rtl/crs_ctrl.sv
`timescale 1ns/1ps
module crs_ctrl
  import crs_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] req_count,
  input  logic [TW-1:0] settle_cfg,
  output logic          req_ready,
  output logic          req_err,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_run,
  input  logic          tmr_expire,
  output logic          addr_load,
  output logic          addr_inc,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          done
);
  localparam logic [CW-1:0] LAST_WORD  = CW'(1);
  localparam logic [TW-1:0] MIN_SETTLE = TW'(1);

  crs_state_e    state_q, state_d;
  logic [CW-1:0] remain_q, remain_d;
  logic [TW-1:0] settle_q, settle_d;
  logic          oe_n_q, oe_n_d;
  logic          ov_q, ov_d;
  logic [DW-1:0] od_q;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          cap_en, hs;
  logic [TW-1:0] settle_eff;

  assign settle_eff = (settle_cfg == '0) ? MIN_SETTLE : settle_cfg;
  assign hs         = ov_q && out_ready;

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    settle_d  = settle_q;
    oe_n_d    = oe_n_q;
    ov_d      = ov_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    cap_en    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = settle_q;
    tmr_run   = 1'b0;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    if (hs) ov_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            err_d = 1'b1;
          end else if (req_count != '0) begin
            addr_load = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = settle_eff;
            settle_d  = settle_eff;
            remain_d  = req_count;
            oe_n_d    = 1'b0;
            state_d   = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        tmr_run = 1'b1;
        if (tmr_expire) begin
          cap_en  = 1'b1;
          ov_d    = 1'b1;
          state_d = (remain_q == LAST_WORD) ? ST_CLOSE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (hs) begin
          addr_inc = 1'b1;
          tmr_load = 1'b1;
          remain_d = remain_q - LAST_WORD;
          state_d  = ST_SETTLE;
        end
      end
      ST_CLOSE: begin
        oe_n_d  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!ov_q || out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      settle_q <= MIN_SETTLE;
      oe_n_q   <= 1'b1;
      ov_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      settle_q <= settle_d;
      oe_n_q   <= oe_n_d;
      ov_q     <= ov_d;
      done_q   <= done_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      od_q <= '0;
    else if (cap_en) od_q <= mem_data;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign req_err   = err_q;
  assign mem_oe_n  = oe_n_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign done      = done_q;

  // R2: output enable is not released mid-burst
  p_oe_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n_q && state_q != ST_CLOSE) |=> !oe_n_q);
  // R5: a stalled word stays put
  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> (ov_q && $stable(od_q)));
  // R6: done is a single-cycle pulse that follows the enable release
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (oe_n_q && $past(!oe_n_q)));
  // R7: a refused write leaves the bus quiet
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (oe_n_q && state_q == ST_IDLE));
  // R8: zero-length reads do nothing
  p_zero_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_count == '0) |=> (oe_n_q && req_ready && !req_err));
  // R9: idle only once nothing is pending downstream
  p_ready_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ov_q && oe_n_q));
endmodule

// File: rtl/crs_stream_reader.sv
`timescale 1ns/1ps
module crs_stream_reader #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int CW         = 8,
  parameter int MAX_SETTLE = 15,
  parameter int TW         = $clog2(MAX_SETTLE + 1)
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  input  logic [TW-1:0] settle_cfg,
  output logic          req_ready,
  output logic          req_err,
  output logic [AW-1:0] mem_addr,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          done
);
  logic          rst_n;
  logic          tmr_load, tmr_run, tmr_expire;
  logic [TW-1:0] tmr_val;
  logic          addr_load, addr_inc;

  crs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (rst_n)
  );

  crs_settle_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expire   (tmr_expire)
  );

  crs_addr_step #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (addr_load),
    .load_addr (req_addr),
    .inc       (addr_inc),
    .addr      (mem_addr)
  );

  crs_ctrl #(.DW(DW), .CW(CW), .TW(TW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_count  (req_count),
    .settle_cfg (settle_cfg),
    .req_ready  (req_ready),
    .req_err    (req_err),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_run    (tmr_run),
    .tmr_expire (tmr_expire),
    .addr_load  (addr_load),
    .addr_inc   (addr_inc),
    .mem_oe_n   (mem_oe_n),
    .mem_data   (mem_data),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .done       (done)
  );

  // R5: the address does not move under a stalled word
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(mem_addr));
  // R3: the address moves only while the enable is low
  p_addr_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$stable(mem_addr)) |-> $past(!mem_oe_n) || $past(req_ready));
endmodule

// File: tb/tb_crs_stream_reader.sv
`timescale 1ns/1ps
module tb_crs_stream_reader;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [TW-1:0] settle_cfg = '0;
  logic          req_ready, req_err, mem_oe_n, out_valid, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data = '0;
  logic [DW-1:0] out_data;
  logic          out_ready = 1'b1;

  always #2 clk = ~clk;

  crs_stream_reader dut (
    .clk(clk), .arst_n(arst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_count(req_count), .settle_cfg(settle_cfg),
    .req_ready(req_ready), .req_err(req_err), .mem_addr(mem_addr),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .done(done)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction

  // consumer: 0 always ready, 1 pseudo-random, 2 held off
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
  end

  // reference model and memory, evaluated mid-cycle
  bit            mon_on = 1'b0;
  int            age = 0;
  logic [AW-1:0] last_a = '0;
  logic          last_oe = 1'b1;
  bit            acc_pend = 1'b0, err_pend = 1'b0;
  logic [AW-1:0] pend_a = '0;
  int            pend_n = 0, pend_s = 1;
  bit            burst_on = 1'b0;
  int            caps = 0, bn = 0, s_eff = 1, close_ph = 0;
  logic [AW-1:0] exp_a = '0;
  logic          prev_ov = 1'b0, prev_rdy = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;

  always @(negedge clk) begin
    if (mon_on && acc_pend) begin
      burst_on = 1'b1; caps = 0; bn = pend_n; s_eff = pend_s; exp_a = pend_a;
    end
    if (mem_addr !== last_a || mem_oe_n !== last_oe) age = 1;
    else age++;
    last_a  = mem_addr;
    last_oe = mem_oe_n;
    mem_data = (!mem_oe_n && age >= s_eff) ? mem_f(mem_addr) : (16'hBAD0 ^ 16'(age));
    if (mon_on) begin
      chk(req_err == err_pend, "R7 error pulse after a write request", 32'(req_err), 32'(err_pend));
      if (prev_ov && !prev_rdy) begin
        chk(out_valid == 1'b1, "R5 valid held under stall", 32'(out_valid), 32'd1);
        chk(mem_addr == prev_addr, "R5 address held under stall", 32'(mem_addr), 32'(prev_addr));
        chk(out_data == prev_data, "R5 data held under stall", 32'(out_data), 32'(prev_data));
      end
      if (close_ph == 1) begin
        chk(mem_oe_n == 1'b1, "R6 enable released after final capture", 32'(mem_oe_n), 32'd1);
        chk(done == 1'b1, "R6 done after final capture", 32'(done), 32'd1);
        close_ph = 2;
      end else if (close_ph == 2) begin
        chk(done == 1'b0, "R6 done lasts one cycle", 32'(done), 32'd0);
        close_ph = 0;
      end else begin
        chk(done == 1'b0, "R6 no stray done", 32'(done), 32'd0);
      end
      if (burst_on && caps < bn)
        chk(mem_oe_n == 1'b0, "R2 enable low through the burst", 32'(mem_oe_n), 32'd0);
      if (burst_on && (caps < bn || out_valid))
        chk(req_ready == 1'b0, "R9 busy while words pending", 32'(req_ready), 32'd0);
      if (!burst_on) begin
        chk(mem_oe_n == 1'b1, "R8 no bus activity outside a burst", 32'(mem_oe_n), 32'd1);
        chk(out_valid == 1'b0, "R8 no word outside a burst", 32'(out_valid), 32'd0);
      end
      if (!prev_ov && out_valid) begin
        chk(burst_on && caps < bn, "R2 capture inside a burst", 32'(caps), 32'(bn));
        chk(age == s_eff + 1, "R4 settle cycles before capture", 32'(age), 32'(s_eff + 1));
        chk(mem_addr == exp_a, "R3 word address", 32'(mem_addr), 32'(exp_a));
        chk(out_data == mem_f(exp_a), "R3 word data", 32'(out_data), 32'(mem_f(exp_a)));
        exp_a = exp_a + 1'b1;
        caps++;
        if (caps == bn) close_ph = 1;
      end
      if (burst_on && caps == bn && close_ph == 0 && !out_valid) burst_on = 1'b0;
      acc_pend = req_valid && req_ready && !req_write && (req_count != '0);
      err_pend = req_valid && req_ready && req_write;
      pend_a = req_addr;
      pend_n = int'(req_count);
      pend_s = (settle_cfg == '0) ? 1 : int'(settle_cfg);
      prev_ov = out_valid; prev_rdy = out_ready;
      prev_addr = mem_addr; prev_data = out_data;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired, run hung");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic issue(input logic [AW-1:0] a, input int n, input int s, input bit w);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1'b1; req_write = w; req_addr = a;
    req_count = CW'(n); settle_cfg = TW'(s);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wait_done();
    do begin @(posedge clk); #1; end while (!done);
  endtask

  task automatic read_burst(input logic [AW-1:0] a, input int n, input int s);
    issue(a, n, s, 1'b0);
    wait_done();
  endtask

  initial begin
    arst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(mem_oe_n == 1'b1, "R1 enable high in reset", 32'(mem_oe_n), 32'd1);
    chk(out_valid == 1'b0, "R1 no word in reset", 32'(out_valid), 32'd0);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(done == 1'b0 && req_err == 1'b0, "R1 pulses low after reset", 32'({done, req_err}), 32'd0);
    chk(mem_oe_n == 1'b1, "R1 enable high after reset", 32'(mem_oe_n), 32'd1);
    mon_on = 1'b1;

    rdy_mode = 0; read_burst(16'h0100, 5, 3);      // R3 R4 plain run
    rdy_mode = 1; read_burst(16'h0200, 6, 1);      // R5 random stalls, shortest settle
    rdy_mode = 0; read_burst(16'h0400, 3, 0);      // R4 zero settle acts as one
    read_burst(16'h0500, 2, 15);                   // R4 longest settle
    rdy_mode = 1; read_burst(16'hFFFE, 4, 2);      // R3 wrap across the top

    issue(16'h0600, 5, 3, 1'b1);                   // R7 write refused
    repeat (6) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R7 still idle after refused write", 32'(req_ready), 32'd1);

    issue(16'h0700, 0, 3, 1'b0);                   // R8 zero count
    repeat (10) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R8 still idle after zero count", 32'(req_ready), 32'd1);
    chk(mem_oe_n == 1'b1, "R8 enable untouched by zero count", 32'(mem_oe_n), 32'd1);

    rdy_mode = 2; read_burst(16'h0300, 1, 4);      // R6 close precedes acceptance
    #0;
    chk(out_valid == 1'b1, "R6 word still offered after done", 32'(out_valid), 32'd1);
    chk(req_ready == 1'b0, "R9 busy until last word taken", 32'(req_ready), 32'd0);
    repeat (4) @(posedge clk);
    rdy_mode = 0;

    rdy_mode = 1; read_burst(16'h1234, 40, 2);     // R2 R3 long burst with stalls
    rdy_mode = 0;
    issue(16'h2000, 3, 1, 1'b0);                   // R9 back-to-back after long run
    wait_done();
    repeat (8) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R9 ready once drained", 32'(req_ready), 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule